// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block is a small memory-mapped register bank that sits beside a storage-interface PHY. Every 32-bit bus write carries a data half in bits 15:0 and a per-bit enable half in bits 31:16. A register bit takes the new value only when its enable bit is set, so software can change one field without first reading the register back. The bank holds seven 16-bit control words at word indices 0 through 6 (byte offsets 0x00 to 0x18). It also has one read-only status word at byte offset 0x20 that shows two PHY status inputs live.

The stored control fields are driven straight out to the PHY. Word 6 carries the power-up release, the DLL enable and the drive-strength code. Word 0 carries the DLL frequency band and the output tap delay enable and value. The bus port is simple: a write strobe, a byte address, and a combinational read data path that follows the address.

Top module: `phy_ctl_regs`

## Requirements
- R1: While reset is asserted and after it is released, every control word reads 0 and every decoded PHY output is 0. The PHY is therefore powered down with its DLL disabled.
- R2: On a write to control word k (byte address 4*k, k = 0..6), bit x of the word (x = 0..15) takes wdata[x] whenever wdata[x+16] is 1.
- R3: On such a write, bit x keeps its previous value whenever wdata[x+16] is 0. A write with an all-zero enable half leaves the word unchanged.
- R4: A read of a control word returns the stored 16 bits in rdata[15:0], and rdata[31:16] reads as 0.
- R5: Word 6 decodes as follows: bit 0 drives phy_pwr_up (1 = powered), bit 1 drives dll_en, and bits 6:4 drive drv_sel. The drive codes are 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm.
- R6: Word 0 decodes as follows: bits 13:12 drive dll_freq (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz), bit 11 drives otap_en, and bits 10:7 drive otap_sel.
- R7: A read at byte offset 0x20 returns cal_done in bit 6 and dll_lock in bit 5, with all other bits 0. The value follows the inputs without delay.
- R8: A write to offset 0x20 or to any unmapped offset changes no control word. A read of any unmapped offset returns 0.
- R9: A write to one control word leaves every other control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write enable half [31:16] and data half [15:0] |
| rdata | output | 32 | Read data for addr (combinational) |
| cal_done | input | 1 | PHY calibration-done status |
| dll_lock | input | 1 | PHY DLL-ready status |
| phy_pwr_up | output | 1 | Power-down release (1 = powered) |
| dll_en | output | 1 | DLL enable |
| drv_sel | output | 3 | Drive-strength code |
| dll_freq | output | 2 | DLL frequency band |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay value |

## Verification
Each control word receives a sequence of writes whose data and enable halves are generated arithmetically, with full, empty and sparse masks. This separates a correct per-bit merge from a plain overwrite and from a merge that uses the wrong half. After every write, all seven words are read back, so a write that leaks into a neighbouring word is caught. The decoded outputs are compared with the modelled words 0 and 6, which shows whether a field has been shifted. All four combinations of the two status inputs are read at 0x20. A sweep of every word index, with writes to the status and unmapped offsets, confirms that those offsets return zero and store nothing.

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs #(
  parameter int ADDR_W   = 8,
  parameter int HALF_W   = 16,
  parameter int N_CTRL   = 7,
  parameter int STAT_IDX = 8,
  parameter int PWR_IDX  = 6,
  parameter int DLL_IDX  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] rdata,
  input  logic                cal_done,
  input  logic                dll_lock,
  output logic                phy_pwr_up,
  output logic                dll_en,
  output logic [2:0]          drv_sel,
  output logic [1:0]          dll_freq,
  output logic                otap_en,
  output logic [3:0]          otap_sel
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int PWR_BIT   = 0;
  localparam int DLLEN_BIT = 1;
  localparam int DRV_LSB   = 4;
  localparam int OTSEL_LSB = 7;
  localparam int OTEN_BIT  = 11;
  localparam int FREQ_LSB  = 12;
  localparam int CAL_BIT   = 6;
  localparam int LOCK_BIT  = 5;

  logic [HALF_W-1:0] ctrl [N_CTRL];
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] wmask, wval;

  assign idx   = addr[ADDR_W-1:2];
  assign wmask = wdata[2*HALF_W-1:HALF_W];
  assign wval  = wdata[HALF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_CTRL; k++) ctrl[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < N_CTRL; k++)
        if (idx == IDX_W'(k)) ctrl[k] <= (ctrl[k] & ~wmask) | (wval & wmask);
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_CTRL; k++)
      if (idx == IDX_W'(k)) rdata[HALF_W-1:0] = ctrl[k];
    if (idx == IDX_W'(STAT_IDX)) begin
      rdata[CAL_BIT]  = cal_done;
      rdata[LOCK_BIT] = dll_lock;
    end
  end

  assign phy_pwr_up = ctrl[PWR_IDX][PWR_BIT];
  assign dll_en     = ctrl[PWR_IDX][DLLEN_BIT];
  assign drv_sel    = ctrl[PWR_IDX][DRV_LSB +: 3];
  assign dll_freq   = ctrl[DLL_IDX][FREQ_LSB +: 2];
  assign otap_en    = ctrl[DLL_IDX][OTEN_BIT];
  assign otap_sel   = ctrl[DLL_IDX][OTSEL_LSB +: 4];
endmodule

// File: rtl/phy_ctl_regs_chk.sv
module phy_ctl_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int N_CTRL   = 7,
  parameter int STAT_IDX = 8,
  parameter int PWR_IDX  = 6,
  parameter int DLL_IDX  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              cal_done,
  input logic              dll_lock,
  input logic              phy_pwr_up,
  input logic              dll_en,
  input logic [2:0]        drv_sel,
  input logic [1:0]        dll_freq,
  input logic              otap_en,
  input logic [3:0]        otap_sel
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] w_idx;
  assign w_idx = addr[ADDR_W-1:2];

  AST_PWR_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_idx == IDX_W'(PWR_IDX) && wdata[16]) |=> (phy_pwr_up == $past(wdata[0]))); // R2
  AST_PWR_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_idx == IDX_W'(PWR_IDX) && !wdata[16]) |=> $stable(phy_pwr_up)); // R3
  AST_W6_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && w_idx == IDX_W'(PWR_IDX)) |=> $stable({phy_pwr_up, dll_en, drv_sel})); // R9
  AST_W0_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && w_idx == IDX_W'(DLL_IDX)) |=> $stable({dll_freq, otap_en, otap_sel})); // R9

  always @(posedge clk) begin
    if (!rst_n)
      AST_RESET_OUTPUTS: assert ({phy_pwr_up, dll_en, drv_sel, dll_freq, otap_en, otap_sel} == '0); // R1
    if (rst_n && w_idx < IDX_W'(N_CTRL))
      AST_CTRL_UPPER_ZERO: assert (rdata[31:16] == 16'h0); // R4
    if (rst_n && w_idx == IDX_W'(STAT_IDX))
      AST_STATUS_READ: assert (rdata == ({31'h0, cal_done} << 6 | {31'h0, dll_lock} << 5)); // R7
  end
endmodule

bind phy_ctl_regs phy_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .STAT_IDX(STAT_IDX), .PWR_IDX(PWR_IDX), .DLL_IDX(DLL_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .cal_done(cal_done), .dll_lock(dll_lock), .phy_pwr_up(phy_pwr_up), .dll_en(dll_en),
  .drv_sel(drv_sel), .dll_freq(dll_freq), .otap_en(otap_en), .otap_sel(otap_sel)
);

// File: tb/sim_phy_ctl_regs.sv
module sim_phy_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 7;

  logic        clk = 0, rst_n = 0, wr_en = 0, cal_done = 0, dll_lock = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        phy_pwr_up, dll_en, otap_en;
  logic [2:0]  drv_sel;
  logic [1:0]  dll_freq;
  logic [3:0]  otap_sel;
  logic [15:0] model [NW];
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .cal_done(cal_done), .dll_lock(dll_lock), .phy_pwr_up(phy_pwr_up), .dll_en(dll_en),
    .drv_sel(drv_sel), .dll_freq(dll_freq), .otap_en(otap_en), .otap_sel(otap_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a[7:2] < NW)
      model[a[7:2]] = (model[a[7:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic all_words(input string req);
    for (int k = 0; k < NW; k++) rd_chk(req, 8'(k*4), {16'h0, model[k]});
  endtask

  task automatic outs_chk(input string req);
    #1;
    chk({req, " R5 pwr/dll/drv"}, {28'h0, phy_pwr_up, dll_en, drv_sel}[4:0],
        {model[6][0], model[6][1], model[6][6:4]});
    chk({req, " R6 freq/otap"}, {25'h0, dll_freq, otap_en, otap_sel},
        {25'h0, model[0][13:12], model[0][11], model[0][10:7]});
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NW; k++) model[k] = 16'h0;
    #(CLK_PERIOD*2 + 2);
    all_words("R1 reset under reset");
    outs_chk("R1 reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    all_words("R1 reset after release");

    // R2 R3 R4 R9 sweep: full, empty, sparse and arithmetic masks
    for (int k = 0; k < NW; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] m, d;
        d = 16'((k + 1) * 16'h3b5d + i * 16'h1f27);
        case (i)
          0: m = 16'hffff;
          1: m = 16'h0000;
          2: m = 16'h00ff;
          3: m = 16'hff00;
          4: m = 16'h5555;
          default: m = 16'((i * 16'h9e37) ^ (k * 16'h0f0f));
        endcase
        wr(8'(k*4), {m, d});
        all_words("R2 R3 R4 R9 masked write");
        outs_chk("R5 R6 decode");
      end
    end

    // R5 drive codes and single-field changes
    for (int c = 0; c < 5; c++) begin
      wr(8'h18, {16'h0070, 16'(c << 4)});
      #1 chk("R5 drive code", {29'h0, drv_sel}, 32'(c));
    end
    wr(8'h18, 32'h0003_0003);
    #1 chk("R5 power/dll on", {30'h0, phy_pwr_up, dll_en}, 32'h3);
    wr(8'h18, 32'h0001_0000);
    #1 chk("R5 power off, dll kept", {30'h0, phy_pwr_up, dll_en}, 32'h1);
    for (int f = 0; f < 4; f++) begin
      wr(8'h00, {16'h3000, 16'(f << 12)});
      #1 chk("R6 freq band", {30'h0, dll_freq}, 32'(f));
    end
    for (int t = 0; t < 16; t++) begin
      wr(8'h00, {16'h0f80, 16'(t << 7) | 16'h0800});
      outs_chk("R6 tap value");
    end

    // R7 status combinations
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); cal_done = s[1]; dll_lock = s[0];
      rd_chk("R7 status", 8'h20, (32'(s[1]) << 6) | (32'(s[0]) << 5));
    end

    // R8 writes to status/unmapped are ignored; unmapped reads zero
    for (int a = 7; a < 64; a++) wr(8'(a*4), 32'hffff_ffff);
    wr(8'h23, 32'hffff_0000);
    all_words("R8 ignored writes");
    outs_chk("R8 outputs kept");
    @(negedge clk); cal_done = 0; dll_lock = 0;
    for (int a = 7; a < 64; a++) rd_chk("R8 unmapped/status read", 8'(a*4), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule